// File: doc/BRIEF.md
# Priority Peripheral-to-Pin Crossbar

This block places a set of digital peripheral functions onto a bank of port pins. Each function has a fixed rank: function 0 ranks highest, and higher indices rank lower. Each function has an enable bit, and each pin has a skip bit. The block walks the enabled functions in rank order. It gives each function the lowest-numbered pin that is neither skipped nor already taken. When the pins run out, a function that is still waiting is left unplaced, and its overflow flag is raised.

The placement is computed combinationally from the enable and skip vectors and is captured in registers on every rising clock edge. The registered map then steers the datapath combinationally. Each placed pin carries its function's output value and output-enable. Each function reads back the value on its pin. An unplaced function reads logic 1. Pins that carry no function are released, with output-enable low and output value 0.

Top module: `pin_xbar`

## Requirements
- R1: While reset is asserted and after it, until the first clock edge with reset released, no pin is assigned, no overflow flag is set, every `pin_oe` bit is 0 and every `func_in` bit is 1.
- R2: Function index 0 has the highest priority. Enabled functions are placed in increasing index order, so a higher-priority function always sits on a lower-numbered pin than a lower-priority one.
- R3: Each enabled function takes the lowest-numbered pin that is not skipped and not already taken by a higher-priority function.
- R4: A pin whose `skip` bit is 1 is never assigned, and its `pin_valid` bit stays 0.
- R5: A disabled function takes no pin and raises no overflow, so the lower-priority functions move down to lower pins.
- R6: An enabled function that finds no free pin is unassigned (`func_asg` bit 0), and its `func_ovf` bit is 1. Functions that were placed have `func_ovf` at 0.
- R7: An unassigned pin drives `pin_oe` = 0 and `pin_out` = 0.
- R8: An assigned pin drives `pin_out` and `pin_oe` from the `func_out` and `func_oe` bits of the function in its `pin_sel` field. `pin_sel` field p occupies bits [p*FW +: FW], where FW = clog2(NFUNC).
- R9: An assigned function's `func_in` bit equals `pin_in` of its pin. `func_pin` field f occupies bits [f*PW +: PW], where PW = clog2(NPIN). An unassigned function's `func_in` bit is 1.
- R10: The map outputs (`pin_valid`, `pin_sel`, `func_asg`, `func_pin`, `func_ovf`) reflect the `func_en` and `skip` values sampled at the previous rising edge. The datapath outputs follow `func_out`, `func_oe` and `pin_in` with no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| func_en | input | NFUNC | Per-function enable |
| skip | input | NPIN | Per-pin exclusion mask |
| func_out | input | NFUNC | Per-function output value |
| func_oe | input | NFUNC | Per-function output enable |
| pin_in | input | NPIN | Value seen on each pin |
| pin_valid | output | NPIN | Pin carries a function |
| pin_sel | output | NPIN*FW | Function index per pin |
| func_asg | output | NFUNC | Function has a pin |
| func_pin | output | NFUNC*PW | Pin index per function |
| func_ovf | output | NFUNC | Enabled function found no free pin |
| pin_out | output | NPIN | Output value per pin |
| pin_oe | output | NPIN | Output enable per pin |
| func_in | output | NFUNC | Pin value routed back to each function |

## Verification
The bench builds the block with 6 functions and 8 pins. With these sizes, all functions fit when few pins are skipped, and overflow appears once three or more pins are skipped with every function enabled. Because the function count is not a power of two, the select field has unused codes. Directed patterns cover an all-clear skip mask, alternating skips, a full skip, and sparse enables. These are followed by a few hundred pseudo-random enable, skip and data vectors. The random vectors mix placement, shifting and overflow in the same map.

// File: rtl/pin_xbar.sv
module pin_xbar #(
  parameter int NFUNC = 6,
  parameter int NPIN  = 8,
  localparam int FW = (NFUNC > 1) ? $clog2(NFUNC) : 1,
  localparam int PW = (NPIN > 1) ? $clog2(NPIN) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NFUNC-1:0]    func_en,
  input  logic [NPIN-1:0]     skip,
  input  logic [NFUNC-1:0]    func_out,
  input  logic [NFUNC-1:0]    func_oe,
  input  logic [NPIN-1:0]     pin_in,
  output logic [NPIN-1:0]     pin_valid,
  output logic [NPIN*FW-1:0]  pin_sel,
  output logic [NFUNC-1:0]    func_asg,
  output logic [NFUNC*PW-1:0] func_pin,
  output logic [NFUNC-1:0]    func_ovf,
  output logic [NPIN-1:0]     pin_out,
  output logic [NPIN-1:0]     pin_oe,
  output logic [NFUNC-1:0]    func_in
);

  logic [NPIN-1:0]            taken, n_valid, valid_q;
  logic [NPIN-1:0][FW-1:0]    n_sel, sel_q;
  logic [NFUNC-1:0]           n_asg, asg_q, n_ovf, ovf_q;
  logic [NFUNC-1:0][PW-1:0]   n_pin, pin_q;
  logic                       found;

  always_comb begin
    taken   = '0;
    n_valid = '0;
    n_sel   = '0;
    n_asg   = '0;
    n_pin   = '0;
    n_ovf   = '0;
    found   = 1'b0;
    for (int f = 0; f < NFUNC; f++) begin
      found = 1'b0;
      if (func_en[f]) begin
        for (int p = 0; p < NPIN; p++) begin
          if (!found && !skip[p] && !taken[p]) begin
            found      = 1'b1;
            taken[p]   = 1'b1;
            n_valid[p] = 1'b1;
            n_sel[p]   = FW'(f);
            n_asg[f]   = 1'b1;
            n_pin[f]   = PW'(p);
          end
        end
        n_ovf[f] = !found;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      sel_q   <= '0;
      asg_q   <= '0;
      pin_q   <= '0;
      ovf_q   <= '0;
    end else begin
      valid_q <= n_valid;
      sel_q   <= n_sel;
      asg_q   <= n_asg;
      pin_q   <= n_pin;
      ovf_q   <= n_ovf;
    end
  end

  assign pin_valid = valid_q;
  assign pin_sel   = sel_q;
  assign func_asg  = asg_q;
  assign func_pin  = pin_q;
  assign func_ovf  = ovf_q;

  always_comb begin
    for (int p = 0; p < NPIN; p++) begin
      pin_out[p] = valid_q[p] & func_out[sel_q[p]];
      pin_oe[p]  = valid_q[p] & func_oe[sel_q[p]];
    end
    for (int f = 0; f < NFUNC; f++)
      func_in[f] = asg_q[f] ? pin_in[pin_q[f]] : 1'b1;
  end

  for (genvar p = 0; p < NPIN; p++) begin : g_pin_chk
    a_r4_skip_free: assert property (@(posedge clk) disable iff (!rst_n)
      pin_valid[p] |-> !$past(skip[p]));
    a_r7_idle_pin: assert property (@(posedge clk) disable iff (!rst_n)
      !pin_valid[p] |-> (!pin_oe[p] && !pin_out[p]));
  end

  for (genvar f = 0; f < NFUNC; f++) begin : g_fn_chk
    a_r5_off_no_pin: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(func_en[f]) |-> (!func_asg[f] && !func_ovf[f]));
    a_r6_ovf_excl: assert property (@(posedge clk) disable iff (!rst_n)
      func_ovf[f] |-> !func_asg[f]);
    a_r9_unplaced_one: assert property (@(posedge clk) disable iff (!rst_n)
      !func_asg[f] |-> func_in[f]);
  end

endmodule

// File: tb/sim_pin_xbar.sv
module sim_pin_xbar;
  localparam int NFUNC = 6;
  localparam int NPIN  = 8;
  localparam int FW = 3;
  localparam int PW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NFUNC-1:0] func_en = '0, func_out = '0, func_oe = '0;
  logic [NPIN-1:0]  skip = '0, pin_in = '0;
  logic [NPIN-1:0]  pin_valid, pin_out, pin_oe;
  logic [NPIN*FW-1:0]  pin_sel;
  logic [NFUNC-1:0] func_asg, func_ovf, func_in;
  logic [NFUNC*PW-1:0] func_pin;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  pin_xbar #(.NFUNC(NFUNC), .NPIN(NPIN)) u0 (
    .clk(clk), .rst_n(rst_n), .func_en(func_en), .skip(skip),
    .func_out(func_out), .func_oe(func_oe), .pin_in(pin_in),
    .pin_valid(pin_valid), .pin_sel(pin_sel), .func_asg(func_asg),
    .func_pin(func_pin), .func_ovf(func_ovf), .pin_out(pin_out),
    .pin_oe(pin_oe), .func_in(func_in));

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Reference: walk enabled functions in priority order, hand out the next non-skipped pin
  task automatic check_model(input logic [NFUNC-1:0] en, input logic [NPIN-1:0] sk);
    int owner [NPIN];
    int where [NFUNC];
    int nxt;
    logic [NPIN-1:0] ev, eo, eoe;
    logic [NFUNC-1:0] ea, eovf, ein;
    logic [NPIN*FW-1:0] esel;
    logic [NFUNC*PW-1:0] epin;
    nxt = 0;
    for (int p = 0; p < NPIN; p++) owner[p] = -1;
    for (int f = 0; f < NFUNC; f++) begin
      where[f] = -1;
      if (en[f]) begin
        while (nxt < NPIN && sk[nxt]) nxt++;
        if (nxt < NPIN) begin
          where[f] = nxt;
          owner[nxt] = f;
          nxt++;
        end
      end
    end
    ev = '0; eo = '0; eoe = '0; esel = '0; ea = '0; eovf = '0; ein = '0; epin = '0;
    for (int p = 0; p < NPIN; p++)
      if (owner[p] >= 0) begin
        ev[p] = 1'b1;
        esel[p*FW +: FW] = FW'(owner[p]);
        eo[p]  = func_out[owner[p]];
        eoe[p] = func_oe[owner[p]];
      end
    for (int f = 0; f < NFUNC; f++) begin
      ea[f]   = (where[f] >= 0);
      eovf[f] = en[f] && (where[f] < 0);
      ein[f]  = (where[f] >= 0) ? pin_in[where[f]] : 1'b1;
      if (where[f] >= 0) epin[f*PW +: PW] = PW'(where[f]);
    end
    chk("R2/R3/R4/R5 pin_valid", pin_valid, ev);
    chk("R2/R3 pin_sel", pin_sel, esel);
    chk("R5/R6 func_asg", func_asg, ea);
    chk("R3 func_pin", func_pin, epin);
    chk("R6 func_ovf", func_ovf, eovf);
    chk("R7/R8 pin_out", pin_out, eo);
    chk("R7/R8 pin_oe", pin_oe, eoe);
    chk("R9 func_in", func_in, ein);
  endtask

  task automatic step(input logic [NFUNC-1:0] en, input logic [NPIN-1:0] sk,
                      input logic [NFUNC-1:0] fo, input logic [NFUNC-1:0] foe,
                      input logic [NPIN-1:0] pi);
    @(negedge clk);
    func_en = en; skip = sk; func_out = fo; func_oe = foe; pin_in = pi;
    @(posedge clk);
    #1;
    check_model(en, sk);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    errors++;
    $display("FAIL watchdog actual=%0d expected=<%0d", cyc, 100000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    func_en = '1; skip = '0; func_oe = '1; func_out = '1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset pin_valid", pin_valid, 0);
    chk("R1 reset func_ovf", func_ovf, 0);
    chk("R1 reset pin_oe", pin_oe, 0);
    chk("R1 reset func_in", func_in, 6'h3f);
    @(negedge clk);
    rst_n = 1'b1;
    chk("R1 before first edge", pin_valid, 0);

    step(6'h3f, 8'h00, 6'h2a, 6'h3f, 8'h5c);
    chk("R3 all fit: f5 on pin5", func_pin[5*PW +: PW], 5);
    step(6'h3f, 8'h55, 6'h15, 6'h33, 8'ha3);
    chk("R6 alternating skip: f4 overflows", func_ovf, 6'h30);
    step(6'h3f, 8'hff, 6'h3f, 6'h3f, 8'hff);
    chk("R4 all skipped: nothing placed", pin_valid, 0);
    step(6'h2a, 8'h01, 6'h3f, 6'h3f, 8'h0f);
    chk("R5 f1 lands on pin1", func_pin[1*PW +: PW], 1);
    step(6'h20, 8'h00, 6'h20, 6'h20, 8'h01);
    chk("R5 lone f5 takes pin0", pin_sel[0 +: FW], 5);
    chk("R8 pin0 drives f5 data", pin_out[0], 1);

    // R10: map follows enables one edge late; datapath follows live inputs
    @(negedge clk);
    func_en = 6'h01; skip = 8'h00; func_out = 6'h01; func_oe = 6'h01;
    #1;
    chk("R10 map not yet updated", pin_sel[0 +: FW], 5);
    chk("R10 datapath live", pin_out[0], 0);
    @(posedge clk);
    #1;
    check_model(6'h01, 8'h00);

    for (int i = 0; i < 300; i++)
      step(NFUNC'($urandom), NPIN'($urandom & $urandom), NFUNC'($urandom),
           NFUNC'($urandom), NPIN'($urandom));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule